// File: doc/BRIEF.md
# Endpoint Status and Interrupt Block

This block keeps the status word and the interrupt state of a single USB device endpoint. The packet engine feeds it single-cycle strobes: a packet finished (with its byte count), a STALL handshake went out, and a halt request arrived from a SET_FEATURE or CLEAR_FEATURE control transfer. It also supplies the current FIFO fill level. Static configuration inputs give the endpoint direction, whether the endpoint is present, the maximum packet size and a FIFO threshold.

Software reads a 16-bit status word. Its five low bits are latched interrupt flags that software clears by writing ones. A 5-bit mask picks which flags drive the single interrupt output. The block works out end of transfer by itself: a short packet ends a transfer, and so does the first zero-length packet that follows full-size packets. On an OUT endpoint it asks the packet engine to answer the host with NAK until software has acknowledged the transfer end.

All events are sampled on the rising clock edge and show up in the status word after that edge.

Top module: `ep_status`

## Requirements
- R1: Halted status (bit 15) becomes 1 one cycle after `feat_set_halt` or `stall_sent` is high, and becomes 0 one cycle after `feat_clr_halt` is high. When set and clear come in the same cycle, set wins. With no request it holds its value.
- R2: The halt flag (bit 1) latches in the same cycle that bit 15 goes from 0 to 1. The unhalt flag (bit 2) latches in the same cycle that bit 15 goes from 1 to 0.
- R3: The end-of-packet flag (bit 3) latches one cycle after every `pkt_done` strobe.
- R4: The end-of-transfer flag (bit 4) latches on a completed packet whose nonzero length is below `cfg_max_pkt`. It also latches on a zero-length packet when the "full packet seen" marker is set. A packet of length at least `cfg_max_pkt` sets that marker, and any end of transfer clears it. A zero-length packet with the marker clear raises nothing.
- R5: `nak_out_o` is 1 exactly while bit 4 is pending and `cfg_is_in` is 0 (OUT endpoint).
- R6: The FIFO-level flag (bit 0) latches when the condition becomes true after being false on the previous cycle. The condition is `fifo_level > cfg_fifo_thresh` for OUT and `fifo_level < cfg_fifo_thresh` for IN. The previous value is taken as false right after reset.
- R7: Bit 14 mirrors `cfg_is_in` (1 = IN), bit 13 mirrors `cfg_present`, and bits 12 to 5 read as 0.
- R8: When `sts_w1c_en` is high, each flag in bits 4 to 0 whose matching `wr_bits` bit is 1 is cleared. Bits written with 0 are unchanged.
- R9: An event and a clear of the same flag in the same cycle leave the flag set.
- R10: When `mask_wr_en` is high, `wr_bits` loads into the mask. `irq_o` is the OR over bits 4 to 0 of (flag AND mask bit).
- R11: Reset clears all flags, the halted status, the full-packet marker and the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_is_in | input | 1 | Endpoint direction, 1 = IN |
| cfg_present | input | 1 | Endpoint is present in the configuration |
| cfg_max_pkt | input | PKT_W | Maximum packet size in bytes |
| cfg_fifo_thresh | input | LVL_W | FIFO threshold |
| pkt_done | input | 1 | Packet completed successfully |
| pkt_len | input | PKT_W | Byte count of the completed packet |
| stall_sent | input | 1 | STALL handshake was sent |
| feat_set_halt | input | 1 | Endpoint-halt set request |
| feat_clr_halt | input | 1 | Endpoint-halt clear request |
| fifo_level | input | LVL_W | Current FIFO fill level |
| sts_w1c_en | input | 1 | Write-one-to-clear strobe for the flags |
| mask_wr_en | input | 1 | Mask write strobe |
| wr_bits | input | 5 | Write data for the flag clear or the mask |
| status_o | output | 16 | Status word |
| mask_o | output | 5 | Interrupt mask |
| irq_o | output | 1 | Combined interrupt |
| nak_out_o | output | 1 | Request to NAK OUT traffic |

## Verification
On every cycle, the assertions check the halt set and hold rules, that the halt and unhalt flags appear together with the status edge, that a packet always leaves the end-of-packet flag set, that a clear with no competing event works, the NAK rule for both directions, and the fixed fields. The end-of-transfer sequencing depends on history: the full-packet marker and a lone zero-length packet or a repeated one. So does the FIFO crossing rule in both directions. The bench shows these through length and level sweeps checked against an arithmetic model, together with a sweep over all 32 mask values.

// File: rtl/ep_stat_pkg.sv
package ep_stat_pkg;
    localparam int unsigned NUM_FLAGS = 5;
    localparam int unsigned STS_W     = 16;
    localparam int unsigned RSVD_W    = STS_W - 3 - NUM_FLAGS;

    localparam int unsigned F_LVL    = 0;
    localparam int unsigned F_HALT   = 1;
    localparam int unsigned F_UNHALT = 2;
    localparam int unsigned F_EOP    = 3;
    localparam int unsigned F_EOT    = 4;

    typedef logic [NUM_FLAGS-1:0] flag_vec_t;

    typedef struct packed {
        flag_vec_t pend;
        flag_vec_t mask;
    } sts_state_t;
endpackage

// File: rtl/ep_halt_trk.sv
module ep_halt_trk (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic halted_o,
    output logic halt_evt_o,
    output logic unhalt_evt_o
);
    logic halt_d, halt_q;

    always_comb begin
        halt_d = halt_q;
        if (set_req)      halt_d = 1'b1;
        else if (clr_req) halt_d = 1'b0;
        halt_evt_o   = halt_d & ~halt_q;
        unhalt_evt_o = ~halt_d & halt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) halt_q <= 1'b0;
        else        halt_q <= halt_d;
    end

    assign halted_o = halt_q;
endmodule

// File: rtl/ep_xfer_end.sv
module ep_xfer_end #(
    parameter int unsigned PKT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_done,
    input  logic [PKT_W-1:0] pkt_len,
    input  logic [PKT_W-1:0] max_len,
    output logic             eot_evt_o
);
    logic full_d, full_q;
    logic zlp, short_pkt;

    always_comb begin
        zlp       = (pkt_len == '0);
        short_pkt = !zlp && (pkt_len < max_len);
        eot_evt_o = pkt_done && (short_pkt || (zlp && full_q));
        full_d    = full_q;
        if (pkt_done) begin
            if (eot_evt_o)  full_d = 1'b0;
            else if (!zlp)  full_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) full_q <= 1'b0;
        else        full_q <= full_d;
    end
endmodule

// File: rtl/ep_fifo_lvl.sv
module ep_fifo_lvl #(
    parameter int unsigned LVL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             is_in,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] thresh,
    output logic             lvl_evt_o
);
    logic cond_d, cond_q;

    always_comb begin
        cond_d    = is_in ? (level < thresh) : (level > thresh);
        lvl_evt_o = cond_d & ~cond_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cond_q <= 1'b0;
        else        cond_q <= cond_d;
    end
endmodule

// File: rtl/ep_status.sv
module ep_status
    import ep_stat_pkg::*;
#(
    parameter int unsigned PKT_W = 11,
    parameter int unsigned LVL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_is_in,
    input  logic             cfg_present,
    input  logic [PKT_W-1:0] cfg_max_pkt,
    input  logic [LVL_W-1:0] cfg_fifo_thresh,
    input  logic             pkt_done,
    input  logic [PKT_W-1:0] pkt_len,
    input  logic             stall_sent,
    input  logic             feat_set_halt,
    input  logic             feat_clr_halt,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic             sts_w1c_en,
    input  logic             mask_wr_en,
    input  logic [4:0]       wr_bits,
    output logic [15:0]      status_o,
    output logic [4:0]       mask_o,
    output logic             irq_o,
    output logic             nak_out_o
);
    sts_state_t st_d, st_q;
    flag_vec_t  evt, clr;
    logic       halted, halt_evt, unhalt_evt, eot_evt, lvl_evt;

    ep_halt_trk u_halt (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_req      (feat_set_halt | stall_sent),
        .clr_req      (feat_clr_halt),
        .halted_o     (halted),
        .halt_evt_o   (halt_evt),
        .unhalt_evt_o (unhalt_evt)
    );

    ep_xfer_end #(.PKT_W(PKT_W)) u_xfer (
        .clk       (clk),
        .rst_n     (rst_n),
        .pkt_done  (pkt_done),
        .pkt_len   (pkt_len),
        .max_len   (cfg_max_pkt),
        .eot_evt_o (eot_evt)
    );

    ep_fifo_lvl #(.LVL_W(LVL_W)) u_lvl (
        .clk       (clk),
        .rst_n     (rst_n),
        .is_in     (cfg_is_in),
        .level     (fifo_level),
        .thresh    (cfg_fifo_thresh),
        .lvl_evt_o (lvl_evt)
    );

    always_comb begin
        evt           = '0;
        evt[F_LVL]    = lvl_evt;
        evt[F_HALT]   = halt_evt;
        evt[F_UNHALT] = unhalt_evt;
        evt[F_EOP]    = pkt_done;
        evt[F_EOT]    = eot_evt;
        clr           = sts_w1c_en ? flag_vec_t'(wr_bits) : '0;

        st_d      = st_q;
        st_d.pend = (st_q.pend & ~clr) | evt;
        if (mask_wr_en) st_d.mask = flag_vec_t'(wr_bits);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o  = {halted, cfg_is_in, cfg_present, {RSVD_W{1'b0}}, st_q.pend};
    assign mask_o    = st_q.mask;
    assign irq_o     = |(st_q.pend & st_q.mask);
    assign nak_out_o = ~cfg_is_in & st_q.pend[F_EOT];
endmodule

// File: rtl/ep_stat_chk.sv
module ep_stat_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       set_any,
    input logic       clr_req,
    input logic       pkt_done,
    input logic       w1c_en,
    input logic       eop_clr_bit,
    input logic       is_in,
    input logic       halt_bit,
    input logic       dir_bit,
    input logic [7:0] rsvd_bits,
    input logic [1:0] hu_bits,
    input logic       eop_bit,
    input logic       eot_bit,
    input logic       nak
);
    AST_HALT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_any |=> halt_bit); // R1
    AST_HALT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_any || clr_req) |=> $stable(halt_bit)); // R1
    AST_HALT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt_bit) |-> hu_bits[0]); // R2
    AST_UNHALT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(halt_bit) |-> hu_bits[1]); // R2
    AST_EOP_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |=> eop_bit); // R3 R9
    AST_NAK_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (eot_bit && !is_in) |-> nak); // R5
    AST_NAK_IN: assert property (@(posedge clk) disable iff (!rst_n)
        is_in |-> !nak); // R5
    AST_W1C_EOP: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c_en && eop_clr_bit && !pkt_done) |=> !eop_bit); // R8
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rsvd_bits == 8'h00); // R7
    AST_DIR_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        dir_bit == is_in); // R7
endmodule

bind ep_status ep_stat_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_any     (feat_set_halt | stall_sent),
    .clr_req     (feat_clr_halt),
    .pkt_done    (pkt_done),
    .w1c_en      (sts_w1c_en),
    .eop_clr_bit (wr_bits[3]),
    .is_in       (cfg_is_in),
    .halt_bit    (status_o[15]),
    .dir_bit     (status_o[14]),
    .rsvd_bits   (status_o[12:5]),
    .hu_bits     (status_o[2:1]),
    .eop_bit     (status_o[3]),
    .eot_bit     (status_o[4]),
    .nak         (nak_out_o)
);

// File: tb/ep_status_bench.sv
module ep_status_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PKT_W = 11;
    localparam int LVL_W = 8;
    localparam int MAXP  = 4;
    localparam int THR   = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_is_in = 1'b0, cfg_present = 1'b1;
    logic [PKT_W-1:0] cfg_max_pkt = PKT_W'(MAXP);
    logic [LVL_W-1:0] cfg_fifo_thresh = LVL_W'(THR);
    logic             pkt_done = 1'b0;
    logic [PKT_W-1:0] pkt_len = '0;
    logic             stall_sent = 1'b0, feat_set_halt = 1'b0, feat_clr_halt = 1'b0;
    logic [LVL_W-1:0] fifo_level = '0;
    logic             sts_w1c_en = 1'b0, mask_wr_en = 1'b0;
    logic [4:0]       wr_bits = '0;
    logic [15:0]      status_o;
    logic [4:0]       mask_o;
    logic             irq_o, nak_out_o;

    int n_checks = 0;
    int n_fail   = 0;

    logic       m_halt = 1'b0, m_full = 1'b0, m_prev = 1'b0;
    logic [4:0] m_pend = '0, m_mask = '0;

    ep_status #(.PKT_W(PKT_W), .LVL_W(LVL_W)) u_ep_status (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        logic       nh, cond;
        logic [4:0] ev, cl;
        nh = m_halt;
        if (feat_set_halt || stall_sent) nh = 1'b1;
        else if (feat_clr_halt)          nh = 1'b0;
        ev    = '0;
        ev[1] = nh & ~m_halt;
        ev[2] = ~nh & m_halt;
        m_halt = nh;
        if (pkt_done) begin
            ev[3] = 1'b1;
            if (pkt_len == 0) begin
                if (m_full) begin ev[4] = 1'b1; m_full = 1'b0; end
            end else if (int'(pkt_len) < MAXP) begin
                ev[4] = 1'b1; m_full = 1'b0;
            end else begin
                m_full = 1'b1;
            end
        end
        cond  = cfg_is_in ? (int'(fifo_level) < THR) : (int'(fifo_level) > THR);
        ev[0] = cond & ~m_prev;
        m_prev = cond;
        cl = sts_w1c_en ? wr_bits : 5'b0;
        m_pend = (m_pend & ~cl) | ev;
        if (mask_wr_en) m_mask = wr_bits;
    endtask

    task automatic compare_all();
        check("R1",  16'(status_o[15]),   16'(m_halt));
        check("R2",  16'(status_o[2:1]),  16'(m_pend[2:1]));
        check("R3",  16'(status_o[3]),    16'(m_pend[3]));
        check("R4",  16'(status_o[4]),    16'(m_pend[4]));
        check("R5",  16'(nak_out_o),      16'(~cfg_is_in & m_pend[4]));
        check("R6",  16'(status_o[0]),    16'(m_pend[0]));
        check("R7",  16'(status_o[14:5]), {6'b0, cfg_is_in, cfg_present, 8'h00});
        check("R10", {10'b0, irq_o, mask_o}, {10'b0, |(m_pend & m_mask), m_mask});
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        #1;
        compare_all();
        @(negedge clk);
        pkt_done = 0; stall_sent = 0; feat_set_halt = 0; feat_clr_halt = 0;
        sts_w1c_en = 0; mask_wr_en = 0; wr_bits = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R11", status_o, 16'h2000);
        check("R11", {11'b0, mask_o}, 16'h0);

        // R1 R2: set, stall, clear, set+clear together, clear while active
        feat_set_halt = 1; step();
        stall_sent = 1;    step();
        feat_clr_halt = 1; step();
        feat_set_halt = 1; feat_clr_halt = 1; step();
        check("R1", 16'(status_o[15]), 16'h1);
        feat_clr_halt = 1; step();
        feat_clr_halt = 1; step();
        stall_sent = 1; feat_clr_halt = 1; step();

        // R8: write zero leaves flags, write ones clears them
        sts_w1c_en = 1; wr_bits = 5'b0; step();
        check("R8", 16'(status_o[2:1]), 16'h3);
        sts_w1c_en = 1; wr_bits = 5'h1F; step();
        check("R8", 16'(status_o[4:0]), 16'h0);

        // R9: packet and clear of its flag in the same cycle
        pkt_done = 1; pkt_len = PKT_W'(2); sts_w1c_en = 1; wr_bits = 5'h18; step();
        check("R9", 16'(status_o[4:3]), 16'h3);
        sts_w1c_en = 1; wr_bits = 5'h1F; step();

        // R4 R5 R3: length sweep in both directions
        for (int d = 0; d < 2; d++) begin
            cfg_is_in = d[0];
            for (int i = 0; i < 90; i++) begin
                pkt_done = 1;
                pkt_len  = PKT_W'((i * 5 + i / 3) % 7);
                if (i % 3 == 0) begin sts_w1c_en = 1; wr_bits = 5'h10; end
                step();
                if (i % 2 == 0) begin sts_w1c_en = 1; wr_bits = 5'h18; end
                step();
            end
            // lone zero-length packets after a short one raise nothing (R4)
            pkt_done = 1; pkt_len = PKT_W'(1); step();
            sts_w1c_en = 1; wr_bits = 5'h10; step();
            pkt_done = 1; pkt_len = '0; step();
            check("R4", 16'(status_o[4]), 16'h0);
            // full then two zero-length packets: only the first ends the transfer
            pkt_done = 1; pkt_len = PKT_W'(MAXP); step();
            pkt_done = 1; pkt_len = '0; step();
            check("R4", 16'(status_o[4]), 16'h1);
            sts_w1c_en = 1; wr_bits = 5'h10; step();
            pkt_done = 1; pkt_len = '0; step();
            check("R4", 16'(status_o[4]), 16'h0);
        end

        // R6: level ramps, clearing the flag as it goes
        for (int d = 0; d < 2; d++) begin
            cfg_is_in = d[0];
            for (int k = 0; k < 40; k++) begin
                fifo_level = LVL_W'((k % 20) < 10 ? (k % 20) : 19 - (k % 20));
                if (k % 4 == 1) begin sts_w1c_en = 1; wr_bits = 5'h01; end
                step();
            end
        end

        // R10: every mask value against a rich set of flags
        cfg_is_in = 1'b0;
        feat_set_halt = 1; step();
        feat_clr_halt = 1; pkt_done = 1; pkt_len = PKT_W'(1); step();
        for (int m = 0; m < 32; m++) begin
            mask_wr_en = 1; wr_bits = 5'(m); step();
            check("R10", {11'b0, mask_o}, 16'(m));
            sts_w1c_en = 1; wr_bits = 5'(m); step();
            if (m % 5 == 0) begin pkt_done = 1; pkt_len = PKT_W'(3); feat_set_halt = 1; end
            else if (m % 5 == 2) feat_clr_halt = 1;
            step();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule